// File: doc/BRIEF.md
# Chip-Select Timing Sequencer

This block frames every serial flash transaction at the pin level. It owns the moment the chip-select line falls, the window in which the serial clock may toggle, and the moment the chip-select line rises again. Around those edges it inserts four programmable guard intervals, each counted in reference clock cycles. The first is the lead time from select to the first clock. The second is the trail time from the last clock to release. The third is a minimum high time between transactions. The fourth is an extra switch time when the next transaction targets a different device. The shift engine and the baud divider are separate blocks. The shift engine raises a one-cycle end indication when its final bit has gone out, and this block then runs the closing part of the sequence.

The four select lines can feed an external decoder. In that mode the 4-bit select field is driven out as written. They can also drive up to four devices directly as active-low one-hot lines. In that mode the lowest-numbered zero bit of the field wins, so at most one line is ever low. Clock polarity and phase are captured when a transaction is accepted. They stay fixed until the next one is accepted. A start request that arrives while a transaction is running is held, one deep, and launched as soon as the minimum high time expires.

Top module: `cs_timing_seq`

## Requirements
- R1: After reset, idle is 1, all four csN lines are high and sclkEn is 0.
- R2: startReq is accepted only while cfgReg bit 0 (enable) is 1. A request made while idle and disabled leaves idle at 1 and csN at all ones.
- R3: A transaction begins with a lead phase of max(delayReg[7:0],1) cycles, in which csN is asserted and sclkEn is 0. sclkEn is then 1 in every cycle until lastBit is sampled.
- R4: After lastBit is sampled, sclkEn is 0 and csN stays asserted for max(delayReg[15:8],1) cycles.
- R5: Once csN is released, it stays at all ones and idle stays 0 for max(delayReg[31:24],1) cycles. This holds even when a request is already waiting.
- R6: A transaction whose select pattern differs from the previous transaction's pattern waits an extra max(delayReg[23:16],1) cycles, with csN all ones and idle 0, before the lead phase. The first transaction after reset never waits.
- R7: With cfgReg bit 9 (decode) set, csN equals cfgReg[13:10] while asserted.
- R8: With decode clear, csN has only bit i low, where i is the lowest index with cfgReg[10+i]=0. If the field is all ones, no line goes low, but the full timing still runs.
- R9: idle is 0 from the cycle after acceptance until the minimum high time ends. A request made while busy is launched when that time ends, and idle does not rise in between.
- R10: sclkPol and sclkPha take cfgReg bits 1 and 2 at acceptance and hold them until the next acceptance.
- R11: lastBit has no effect outside the clocking phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle transaction request |
| lastBit | input | 1 | Final serial bit done, from the shift engine |
| cfgReg | input | 32 | Configuration: enable, polarity, phase, decode, select field |
| delayReg | input | 32 | Four packed 8-bit guard counts |
| sclkEn | output | 1 | Serial clock may toggle |
| csN | output | 4 | Chip-select lines, active low |
| sclkPol | output | 1 | Captured clock polarity |
| sclkPha | output | 1 | Captured clock phase |
| idle | output | 1 | Sequencer idle |

## Verification
The bench aims at the zero-count guard fields. A design that took zero literally would clock the flash in the same cycle that select falls. It also chains a waiting request directly behind a release. A design that skipped the minimum high time, or let idle blip high, would show up as a short high window or a spurious idle. The bench alternates select patterns to expose a missing or misplaced switch wait, and checks that the first transaction after reset pays none. In direct mode it uses fields with several zero bits and the all-ones field, where the wrong priority or a broken one-hot rule would pull two lines low.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;
  localparam int CS_W = 4;
  localparam int DLY_W = 8;
  localparam int NUM_DLY = 4;
  localparam int CFG_W = 32;
  localparam int CFG_EN = 0;
  localparam int CFG_POL = 1;
  localparam int CFG_PHA = 2;
  localparam int CFG_DEC = 9;
  localparam int CFG_SEL_LSB = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SWITCH, ST_LEAD, ST_ACTIVE, ST_TRAIL, ST_GAP
  } seq_state_e;

  // values are the field index inside the packed delay register
  typedef enum logic [1:0] {
    DLY_LEAD = 2'd0, DLY_TRAIL = 2'd1, DLY_SWITCH = 2'd2, DLY_GAP = 2'd3
  } dly_sel_e;

  typedef struct packed {
    logic     loadCnt;
    dly_sel_e cntSel;
    logic     latchTgt;
    logic     commitPrev;
    logic     csActive;
  } seq_strobe_t;
endpackage

// File: rtl/cs_timing_dpath.sv
module cs_timing_dpath
  import cs_timing_pkg::*;
#(
  parameter int CsW = CS_W,
  parameter int DlyW = DLY_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seq_strobe_t             strobe,
  input  logic                    decodeMode,
  input  logic [CsW-1:0]          selField,
  input  logic                    polIn,
  input  logic                    phaIn,
  input  logic [NUM_DLY*DlyW-1:0] delayReg,
  output logic                    cntDone,
  output logic                    diffTgt,
  output logic [CsW-1:0]          csN,
  output logic                    sclkPol,
  output logic                    sclkPha
);
  logic [DlyW-1:0] dlyField [NUM_DLY];
  logic [DlyW-1:0] rawDly, loadVal, cntQ;
  logic [CsW-1:0]  directWord, targetWord, curTgt, prevTgt;
  logic            hasPrev, curDecode;

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_field
    assign dlyField[g] = delayReg[g*DlyW +: DlyW];
  end

  // a zero count behaves as one cycle
  assign rawDly  = dlyField[strobe.cntSel];
  assign loadVal = (rawDly == '0) ? '0 : rawDly - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (strobe.loadCnt) cntQ <= loadVal;
    else if (cntQ != '0) cntQ <= cntQ - 1'b1;
  end
  assign cntDone = (cntQ == '0);

  // direct mode: lowest-numbered zero bit wins
  always_comb begin
    directWord = '1;
    for (int i = CsW - 1; i >= 0; i--) begin
      if (!selField[i]) begin
        directWord    = '1;
        directWord[i] = 1'b0;
      end
    end
  end
  assign targetWord = decodeMode ? selField : directWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTgt    <= '1;
      curDecode <= 1'b0;
      sclkPol   <= 1'b0;
      sclkPha   <= 1'b0;
    end else if (strobe.latchTgt) begin
      curTgt    <= targetWord;
      curDecode <= decodeMode;
      sclkPol   <= polIn;
      sclkPha   <= phaIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTgt <= '1;
      hasPrev <= 1'b0;
    end else if (strobe.commitPrev) begin
      prevTgt <= curTgt;
      hasPrev <= 1'b1;
    end
  end

  assign diffTgt = hasPrev && (targetWord != prevTgt);
  assign csN     = strobe.csActive ? curTgt : '1;

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchTgt |=> $stable({sclkPol, sclkPha}));
  p_direct_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    !curDecode |-> $onehot0(~csN));
endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
  import cs_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        lastBit,
  input  logic        enable,
  input  logic        cntDone,
  input  logic        diffTgt,
  output seq_strobe_t strobe,
  output logic        sclkEn,
  output logic        idle
);
  seq_state_e stateQ, nextState;
  logic       pendQ, launch, gapEnd;

  assign gapEnd = (stateQ == ST_GAP) && cntDone;

  always_comb begin
    nextState = stateQ;
    strobe    = '0;
    sclkEn    = 1'b0;
    launch    = 1'b0;
    case (stateQ)
      ST_IDLE: launch = startReq && enable;
      ST_SWITCH: if (cntDone) begin
        nextState     = ST_LEAD;
        strobe.loadCnt = 1'b1;
        strobe.cntSel  = DLY_LEAD;
      end
      ST_LEAD: begin
        strobe.csActive = 1'b1;
        if (cntDone) nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        strobe.csActive = 1'b1;
        sclkEn          = 1'b1;
        if (lastBit) begin
          nextState      = ST_TRAIL;
          strobe.loadCnt = 1'b1;
          strobe.cntSel  = DLY_TRAIL;
        end
      end
      ST_TRAIL: begin
        strobe.csActive = 1'b1;
        if (cntDone) begin
          nextState         = ST_GAP;
          strobe.loadCnt    = 1'b1;
          strobe.cntSel     = DLY_GAP;
          strobe.commitPrev = 1'b1;
        end
      end
      ST_GAP: if (cntDone) begin
        if (enable && (pendQ || startReq)) launch = 1'b1;
        else nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (launch) begin
      strobe.latchTgt = 1'b1;
      strobe.loadCnt  = 1'b1;
      if (diffTgt) begin
        nextState     = ST_SWITCH;
        strobe.cntSel = DLY_SWITCH;
      end else begin
        nextState     = ST_LEAD;
        strobe.cntSel = DLY_LEAD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else if (gapEnd) pendQ <= 1'b0;
    else if (startReq && stateQ != ST_IDLE) pendQ <= 1'b1;
  end

  assign idle = (stateQ == ST_IDLE);

  p_disabled_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && startReq && !enable) |=> idle);
  p_trail_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && lastBit) |=> (stateQ == ST_TRAIL && !sclkEn));
  p_idle_after_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> ($past(stateQ) == ST_GAP));
  p_pending_no_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gapEnd && pendQ && enable) |=> !idle);
  p_last_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (idle && lastBit && !startReq) |=> idle);
endmodule

// File: rtl/cs_timing_seq.sv
module cs_timing_seq
  import cs_timing_pkg::*;
#(
  parameter int CsW = CS_W,
  parameter int DlyW = DLY_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic                    lastBit,
  input  logic [CFG_W-1:0]        cfgReg,
  input  logic [NUM_DLY*DlyW-1:0] delayReg,
  output logic                    sclkEn,
  output logic [CsW-1:0]          csN,
  output logic                    sclkPol,
  output logic                    sclkPha,
  output logic                    idle
);
  localparam int SelMsb = CFG_SEL_LSB + CsW - 1;

  seq_strobe_t strobe;
  logic        cntDone, diffTgt;
  logic        unusedCfgBits;

  assign unusedCfgBits = ^{cfgReg[CFG_W-1:SelMsb+1], cfgReg[CFG_DEC-1:CFG_PHA+1]};

  cs_timing_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastBit(lastBit),
    .enable(cfgReg[CFG_EN]), .cntDone(cntDone), .diffTgt(diffTgt),
    .strobe(strobe), .sclkEn(sclkEn), .idle(idle)
  );

  cs_timing_dpath #(.CsW(CsW), .DlyW(DlyW)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .decodeMode(cfgReg[CFG_DEC]), .selField(cfgReg[SelMsb:CFG_SEL_LSB]),
    .polIn(cfgReg[CFG_POL]), .phaIn(cfgReg[CFG_PHA]), .delayReg(delayReg),
    .cntDone(cntDone), .diffTgt(diffTgt), .csN(csN),
    .sclkPol(sclkPol), .sclkPha(sclkPha)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (csN == '1 && !sclkEn));
endmodule

// File: tb/cs_timing_seq_tb.sv
`timescale 1ns/1ps
module cs_timing_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        lastBit = 1'b0;
  logic [31:0] cfgReg = '0;
  logic [31:0] delayReg = '0;
  logic        sclkEn, sclkPol, sclkPha, idle;
  logic [3:0]  csN;
  int          total = 0;
  int          bad = 0;
  logic [3:0]  prevPat = 4'hF;
  bit          hasPrev = 0;

  always #10 clk = ~clk;

  cs_timing_seq dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastBit(lastBit),
    .cfgReg(cfgReg), .delayReg(delayReg), .sclkEn(sclkEn), .csN(csN),
    .sclkPol(sclkPol), .sclkPha(sclkPha), .idle(idle)
  );

  task automatic chk(input bit ok, input string tag, input int actV, input int expV);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actV, expV);
    end
  endtask

  function automatic logic [3:0] mkPat(input logic [31:0] c);
    logic [3:0] p;
    if (c[9]) return c[13:10];
    p = 4'hF;
    for (int i = 3; i >= 0; i--) if (!c[10+i]) begin p = 4'hF; p[i] = 1'b0; end
    return p;
  endfunction

  function automatic int c1(input logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  function automatic logic [31:0] mkCfg(input bit dec, input logic [3:0] fld, input bit pol, input bit pha);
    logic [31:0] c;
    c = '0; c[0] = 1'b1; c[1] = pol; c[2] = pha; c[9] = dec; c[13:10] = fld;
    return c;
  endfunction

  task automatic waitSclk();
    for (int g = 0; g < 500 && !sclkEn; g++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int g = 0; g < 500 && !idle; g++) @(negedge clk);
  endtask

  // one full transaction with phase measurement
  task automatic doTxn(input int actLen);
    logic [3:0] pat;
    logic [1:0] mode;
    int sw, expPre, expLead, expTrail, expGap;
    int pre, lead, act, trail, gap, patBad, modeBad, guard;
    bit seenClk, done, firstBusy;
    pat = mkPat(cfgReg);
    mode = {cfgReg[1], cfgReg[2]};
    sw = (hasPrev && pat != prevPat) ? c1(delayReg[23:16]) : 0;
    if (pat != 4'hF) begin
      expPre = sw; expLead = c1(delayReg[7:0]);
      expTrail = c1(delayReg[15:8]); expGap = c1(delayReg[31:24]);
    end else begin
      expPre = sw + c1(delayReg[7:0]); expLead = 0;
      expTrail = 0; expGap = c1(delayReg[15:8]) + c1(delayReg[31:24]);
    end
    pre = 0; lead = 0; act = 0; trail = 0; gap = 0; patBad = 0; modeBad = 0;
    guard = 0; seenClk = 0; done = 0;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    firstBusy = !idle;
    while (!done && guard < 2000) begin
      if (idle) done = 1;
      else begin
        if (sclkEn) begin
          act++; seenClk = 1;
          if (act == actLen) lastBit = 1'b1;
        end else if (!seenClk) begin
          if (csN == 4'hF) pre++; else lead++;
        end else begin
          if (csN != 4'hF) trail++; else gap++;
        end
        if (csN != 4'hF && csN != pat) patBad++;
        if ({sclkPol, sclkPha} != mode) modeBad++;
        @(negedge clk); lastBit = 1'b0; guard++;
      end
    end
    chk(done, "R9 txn finishes", guard, 0);
    chk(firstBusy, "R9 idle drops after accept", 0, 1);
    chk(pre == expPre, "R6 switch wait", pre, expPre);
    chk(lead == expLead, "R3 lead", lead, expLead);
    chk(act == actLen, "R3 clock window", act, actLen);
    chk(trail == expTrail, "R4 trail", trail, expTrail);
    chk(gap == expGap, "R5 min high", gap, expGap);
    if (cfgReg[9]) chk(patBad == 0, "R7 decode pattern", patBad, 0);
    else chk(patBad == 0, "R8 direct pattern", patBad, 0);
    chk(modeBad == 0, "R10 mode held", modeBad, 0);
    hasPrev = 1; prevPat = pat;
  endtask

  // second request made while busy, launched behind the first
  task automatic pendTest(input logic [31:0] cfgB);
    logic [3:0] patA, patB;
    int hi, expHi;
    bit idleSeen;
    patA = mkPat(cfgReg); patB = mkPat(cfgB);
    expHi = c1(delayReg[31:24]) + ((patB != patA) ? c1(delayReg[23:16]) : 0);
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    waitSclk();
    startReq = 1'b1; lastBit = 1'b1; cfgReg = cfgB;
    @(negedge clk); startReq = 1'b0; lastBit = 1'b0;
    for (int g = 0; g < 500 && csN != 4'hF; g++) @(negedge clk);
    hi = 0; idleSeen = 0;
    for (int g = 0; g < 500 && csN == 4'hF; g++) begin
      if (idle) idleSeen = 1;
      hi++;
      @(negedge clk);
    end
    chk(hi == expHi, "R5 high time with waiting request", hi, expHi);
    chk(!idleSeen, "R9 no idle between chained", idleSeen, 0);
    chk(csN == patB, "R9 chained pattern", csN, patB);
    waitSclk();
    lastBit = 1'b1; @(negedge clk); lastBit = 1'b0;
    waitIdle();
    chk(idle, "R9 chained ends", idle, 1);
    prevPat = patB;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(idle && csN == 4'hF && !sclkEn, "R1 reset state", {idle, csN, sclkEn}, 6'b111110);

    lastBit = 1'b1; @(negedge clk); lastBit = 1'b0; @(negedge clk);
    chk(idle && !sclkEn && csN == 4'hF, "R11 lastBit while idle", idle, 1);

    cfgReg = mkCfg(1, 4'h3, 0, 0); cfgReg[0] = 1'b0;
    @(negedge clk); startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    repeat (4) @(negedge clk);
    chk(idle && csN == 4'hF, "R2 start while disabled", {idle, csN}, 5'b11111);

    // first after reset, all counts zero
    cfgReg = mkCfg(1, 4'hA, 1, 0); delayReg = 32'h0;
    doTxn(1);
    // direct mode, several zero bits, with switch wait
    cfgReg = mkCfg(0, 4'b0110, 0, 1); delayReg = {8'd3, 8'd4, 8'd2, 8'd5};
    doTxn(3);
    // same target again: no switch
    doTxn(2);
    // direct mode with no device selected
    cfgReg = mkCfg(0, 4'hF, 1, 1); delayReg = {8'd2, 8'd3, 8'd1, 8'd2};
    doTxn(2);
    // long lead
    cfgReg = mkCfg(0, 4'b1011, 0, 0); delayReg = {8'd1, 8'd2, 8'd1, 8'd20};
    doTxn(4);
    // chained requests: same target, then a different one
    delayReg = {8'd4, 8'd3, 8'd2, 8'd2};
    pendTest(mkCfg(0, 4'b1011, 1, 0));
    pendTest(mkCfg(1, 4'h2, 0, 1));

    for (int n = 0; n < 40; n++) begin
      cfgReg = mkCfg($urandom % 2, 4'($urandom), $urandom % 2, $urandom % 2);
      delayReg = {8'($urandom % 7), 8'($urandom % 7), 8'($urandom % 7), 8'($urandom % 7)};
      doTxn(1 + int'($urandom % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule